// File: doc/BRIEF.md
# Serial EEPROM command interface

This block is the device-side serial front end of a word-organised nonvolatile memory. The memory array is modelled here as a register array of 16-bit words. The block oversamples three pins with the system clock: an active-low chip select, a serial clock and a serial data input. While chip select is low, every rising serial-clock edge shifts in one frame bit.

A frame opens with a four-bit start pattern. An opcode nibble follows, and that nibble also carries the lowest address bits. The rest of the address follows, least significant bit first. The block runs four commands: read, write, write enable and write disable. A read streams words out on falling serial-clock edges and keeps stepping the address for as long as the clock runs. An accepted write is stored into the array and handed to an external write-cycle controller as a one-cycle request. That controller returns a busy flag, and the block refuses new commands while the flag is high.

The parameter `ADDR_W` selects the 512-word organisation (9) or the 1024-word organisation (10). In the larger one, both opcode-nibble tail bits carry address bits.

Top module: `eeprom_serial_if`

## Requirements
- R1: After reset the block is write-disabled, the data output is not driven (`sdoOe` low) and `wrReq` is low; a write frame sent before any enable command produces no `wrReq`.
- R2: A frame is acted on only if its first four bits are 1,0,1,0 and its opcode nibble is a known command; any other frame produces no output drive and no write request.
- R3: With `ADDR_W`=9, bits 5..8 of the frame are 1,0,0,A0 for a read, and A1..A8 follow. From the falling edge of the 16th serial clock on, `sdo` is driven and presents bits D0..D15 of the addressed word, one per falling edge, least significant first.
- R4: If clocking continues during a read, the word at the next address starts at the falling edge of clock 32, and again every 16 clocks after that. The address wraps from the top word to word 0.
- R5: A write frame has opcode nibble 0,1,0,A0, then A1..A8, then D0..D15, all LSB first. Once it is accepted, `wrReq` pulses for one cycle with `wrAddr`/`wrData` set, and the array holds the new word.
- R6: Opcode nibble 0,0,1,1 sets the write-enable latch and 0,0,0,0 clears it. A write frame that arrives while the latch is clear is discarded.
- R7: A write frame is discarded if `wrCtl` is high when its 32nd bit has arrived. `wrCtl` has no effect on read, enable or disable frames.
- R8: Chip select going high ends any frame. A read stops, `sdoOe` drops, and a write frame with fewer than 32 bits is discarded.
- R9: A frame whose header completes while `busy` is high is ignored: a read drives nothing, and a write or enable/disable changes nothing.
- R10: Serial clocks after the 32nd bit of a write frame, or after the 16th bit of an enable/disable frame, have no effect; each write frame gives at most one `wrReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; input bits are taken on rising edges, output bits change on falling edges |
| sdi | input | 1 | Serial data input |
| wrCtl | input | 1 | Write control; high blocks the hand-off of write frames |
| busy | input | 1 | Busy flag from the write-cycle controller |
| sdo | output | 1 | Serial data output value |
| sdoOe | output | 1 | Output enable for `sdo`; low means high impedance |
| wrReq | output | 1 | One-cycle write hand-off strobe |
| wrAddr | output | ADDR_W | Word address of the handed-off write |
| wrData | output | 16 | Data word of the handed-off write |

## Verification
Several rules are checked by assertions on every cycle. A write request never appears unless the enable latch is set, write control was low and busy was low. A request never lasts more than one cycle. Chip select high always releases the output one cycle later. Only the bench scenarios can show the content-dependent behaviour: the LSB-first address and data order, the exact falling edge on which each output bit appears, sequential read across a word boundary and the wrap from the top word, and rejection of frames with a bad start pattern or a bad opcode.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;
  localparam int DATA_W   = 16;
  localparam int HDR_BITS = 16;
  localparam int CNT_W    = 6;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_WEN, CMD_WDS
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_READ, ST_WDATA, ST_SKIP
  } state_t;

  typedef struct packed {
    logic       capHdr;
    logic       capData;
    logic [3:0] bitPos;
    logic       loadRd;
    logic       shiftOut;
    logic       commit;
    logic       abort;
  } strb_t;
endpackage

// File: rtl/eeprom_ctl.sv
module eeprom_ctl
  import eeprom_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  csN,
  input  logic  sclk,
  input  logic  busy,
  input  logic  wrCtl,
  input  cmd_t  cmd,
  output strb_t strb,
  output logic  wenQ
);
  state_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic sclkQ, wenNxt, rise, fall;

  assign rise = sclk & ~sclkQ;
  assign fall = ~sclk & sclkQ;

  always_comb begin
    strb        = '0;
    strb.bitPos = cnt[3:0];
    stateNxt    = state;
    cntNxt      = cnt;
    wenNxt      = wenQ;
    if (csN) begin
      strb.abort = 1'b1;
      stateNxt   = ST_IDLE;
      cntNxt     = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNxt = ST_HDR;
          if (rise) begin
            strb.capHdr = 1'b1;
            cntNxt      = cnt + 1'b1;
          end
        end
        ST_HDR: begin
          if (cnt == CNT_W'(HDR_BITS)) begin
            stateNxt = ST_SKIP;
            if (!busy) begin
              unique case (cmd)
                CMD_READ:  begin strb.loadRd = 1'b1; stateNxt = ST_READ; end
                CMD_WRITE: stateNxt = ST_WDATA;
                CMD_WEN:   wenNxt = 1'b1;
                CMD_WDS:   wenNxt = 1'b0;
                default:   ;
              endcase
            end
          end else if (rise) begin
            strb.capHdr = 1'b1;
            cntNxt      = cnt + 1'b1;
          end
        end
        ST_WDATA: begin
          if (cnt == CNT_W'(HDR_BITS + DATA_W)) begin
            strb.commit = wenQ & ~wrCtl & ~busy;
            stateNxt    = ST_SKIP;
          end else if (rise) begin
            strb.capData = 1'b1;
            cntNxt       = cnt + 1'b1;
          end
        end
        ST_READ: strb.shiftOut = fall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sclkQ <= 1'b0;
      wenQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      sclkQ <= sclk;
      wenQ  <= wenNxt;
    end
  end
endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  strb_t             strb,
  output cmd_t              cmd,
  output logic              sdo,
  output logic              sdoOe,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int WORDS = 1 << ADDR_W;

  logic [HDR_BITS-1:0] hdr;
  logic [DATA_W-1:0]   dataReg;
  logic [DATA_W-1:0]   mem [WORDS];
  logic [ADDR_W-1:0]   hdrAddr, rdAddr;
  logic [3:0]          outIdx;
  logic                isRead, isWrite, startOk;

  // The opcode nibble is hdr[7:4] (frame bits 5..8); the address bits that
  // ride in its tail depend on the organisation.
  generate
    if (ADDR_W == 9) begin : g_org512
      assign isRead  = hdr[4] & ~hdr[5] & ~hdr[6];
      assign isWrite = ~hdr[4] & hdr[5] & ~hdr[6];
      assign hdrAddr = {hdr[15:8], hdr[7]};
    end else begin : g_org1024
      assign isRead  = hdr[4] & ~hdr[5];
      assign isWrite = ~hdr[4] & hdr[5];
      assign hdrAddr = {hdr[15:8], hdr[7:6]};
    end
  endgenerate

  assign startOk = (hdr[3:0] == 4'b0101);

  always_comb begin
    cmd = CMD_NONE;
    if (startOk) begin
      if (isRead)                   cmd = CMD_READ;
      else if (isWrite)             cmd = CMD_WRITE;
      else if (hdr[7:4] == 4'b1100) cmd = CMD_WEN;
      else if (hdr[7:4] == 4'b0000) cmd = CMD_WDS;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capHdr)  hdr[strb.bitPos]     <= sdi;
    if (strb.capData) dataReg[strb.bitPos] <= sdi;
    if (strb.commit)  mem[hdrAddr]         <= dataReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdo    <= 1'b0;
      sdoOe  <= 1'b0;
      rdAddr <= '0;
      outIdx <= '0;
      wrReq  <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrReq <= strb.commit;
      if (strb.commit) begin
        wrAddr <= hdrAddr;
        wrData <= dataReg;
      end
      if (strb.abort) begin
        sdoOe <= 1'b0;
      end else if (strb.loadRd) begin
        rdAddr <= hdrAddr;
        outIdx <= '0;
      end else if (strb.shiftOut) begin
        sdo    <= mem[rdAddr][outIdx];
        sdoOe  <= 1'b1;
        outIdx <= outIdx + 1'b1;
        if (outIdx == 4'd15) rdAddr <= rdAddr + 1'b1;
      end
    end
  end

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> !sdoOe);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq);
endmodule

// File: rtl/eeprom_serial_if.sv
module eeprom_serial_if
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              wrCtl,
  input  logic              busy,
  output logic              sdo,
  output logic              sdoOe,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  strb_t strb;
  cmd_t  cmd;
  logic  wenQ;

  eeprom_ctl ctl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .busy(busy),
    .wrCtl(wrCtl), .cmd(cmd), .strb(strb), .wenQ(wenQ)
  );

  eeprom_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strb(strb), .cmd(cmd),
    .sdo(sdo), .sdoOe(sdoOe), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData)
  );

  assert_wr_needs_wen_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> wenQ);

  assert_wr_blocked_wc_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !$past(wrCtl));

  assert_wr_blocked_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !$past(busy));
endmodule

// File: tb/eeprom_serial_if_tb.sv
module eeprom_serial_if_tb_top;
  localparam int AW = 9;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0, wrCtl = 1'b0, busy = 1'b0;
  logic sdo, sdoOe, wrReq;
  logic [AW-1:0] wrAddr;
  logic [15:0]   wrData;

  int checks = 0, fails = 0, cycles = 0, csHigh = 0;
  bit finished = 0;

  logic [15:0] modelMem [NW];
  bit          modelWen = 0;
  int          expA[$], expD[$], gotA[$], gotD[$];

  eeprom_serial_if #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .wrCtl(wrCtl), .busy(busy), .sdo(sdo), .sdoOe(sdoOe),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Every-clock comparison against the model: idle pins mean a released output.
  always @(negedge clk) begin
    cycles++;
    if (wrReq) begin gotA.push_back(int'(wrAddr)); gotD.push_back(int'(wrData)); end
    csHigh = csN ? csHigh + 1 : 0;
    if (rstN && csHigh >= 2) chk(sdoOe == 1'b0, "R8 idle output released", int'(sdoOe), 0);
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdi = b;
    waitClk(3); sclk = 1'b1;
    waitClk(3); sclk = 1'b0;
  endtask

  // kind: 0 read, 1 write, 2 enable, 3 disable, 4 bad start, 5 bad opcode
  task automatic sendHdr(input int kind, input int addr);
    logic [3:0] st, op;
    st = (kind == 4) ? 4'b1110 : 4'b1010;
    case (kind)
      1:       op = {3'b010, addr[0]};
      2:       op = 4'b0011;
      3:       op = 4'b0000;
      5:       op = {3'b110, addr[0]};
      default: op = {3'b100, addr[0]};
    endcase
    csN = 1'b0; waitClk(2);
    for (int i = 3; i >= 0; i--) pulse(st[i]);
    for (int i = 3; i >= 0; i--) pulse(op[i]);
    for (int i = 1; i <= 8; i++) pulse(addr[i]);
  endtask

  task automatic endFrame();
    waitClk(3); csN = 1'b1; waitClk(4);
  endtask

  task automatic doCmd(input int kind, input int extra);
    sendHdr(kind, 0);
    for (int i = 0; i < extra; i++) pulse(1'b1);
    endFrame();
    if (!busy && kind == 2) modelWen = 1;
    if (!busy && kind == 3) modelWen = 0;
  endtask

  task automatic doWrite(input int addr, input logic [15:0] d, input int nBits, input int extra);
    sendHdr(1, addr);
    for (int i = 0; i < nBits; i++) pulse(d[i]);
    for (int i = 0; i < extra; i++) pulse(1'b0);
    endFrame();
    if (nBits == 16 && modelWen && !wrCtl && !busy) begin
      expA.push_back(addr); expD.push_back(int'(d));
      modelMem[addr] = d;
    end
  endtask

  task automatic checkWrites(input string tag);
    chk(gotA.size() == expA.size(), tag, gotA.size(), expA.size());
    for (int i = 0; i < expA.size() && i < gotA.size(); i++) begin
      chk(gotA[i] == expA[i], tag, gotA[i], expA[i]);
      chk(gotD[i] == expD[i], tag, gotD[i], expD[i]);
    end
    gotA.delete(); gotD.delete(); expA.delete(); expD.delete();
  endtask

  // Reads nWords words; live=0 expects the output to stay released.
  task automatic doRead(input int kind, input int addr, input int nWords, input bit live, input string tag);
    logic [15:0] w;
    sendHdr(kind, addr);
    for (int k = 0; k < nWords; k++) begin
      bit oeOk = 1;
      w = '0;
      for (int b = 0; b < 16; b++) begin
        waitClk(3);
        w[b] = sdo;
        if (sdoOe !== live) oeOk = 0;
        sclk = 1'b1; waitClk(3); sclk = 1'b0;
      end
      chk(oeOk, {tag, " output enable"}, int'(oeOk), 1);
      if (live) chk(w == modelMem[(addr + k) % NW], tag, int'(w), int'(modelMem[(addr + k) % NW]));
    end
    endFrame();
  endtask

  initial begin
    waitClk(3);
    chk(sdoOe == 1'b0 && wrReq == 1'b0, "R1 reset outputs", int'({sdoOe, wrReq}), 0);
    rstN = 1'b1; waitClk(3);
    chk(sdoOe == 1'b0, "R1 output released after reset", int'(sdoOe), 0);

    doWrite(5, 16'h1111, 16, 0);
    checkWrites("R1 write before enable discarded");

    doCmd(2, 0);
    doWrite(5, 16'hA5C3, 16, 0);
    doWrite(6, 16'h0F0F, 16, 0);
    checkWrites("R5 write hand-off");

    doRead(0, 5, 1, 1, "R3 read word");
    doRead(0, 5, 2, 1, "R4 sequential read");

    doWrite(NW - 1, 16'h8001, 16, 0);
    doWrite(0, 16'h7E42, 16, 0);
    checkWrites("R5 write top and bottom");
    doRead(0, NW - 1, 2, 1, "R4 wrap to word 0");

    doWrite(9, 16'hBEEF, 16, 12);
    checkWrites("R10 extra clocks after write");

    busy = 1'b1;
    doWrite(5, 16'hDEAD, 16, 0);
    checkWrites("R9 write while busy");
    doRead(0, 5, 1, 0, "R9 read while busy");
    doCmd(3, 0);
    busy = 1'b0;
    doWrite(7, 16'h3C3C, 16, 0);
    checkWrites("R9 disable while busy ignored");

    wrCtl = 1'b1;
    doWrite(5, 16'h0000, 16, 0);
    checkWrites("R7 write blocked by write control");
    doRead(0, 5, 1, 1, "R7 read unaffected by write control");
    doCmd(3, 0);
    wrCtl = 1'b0;
    doWrite(8, 16'h5555, 16, 0);
    checkWrites("R7 disable works with write control high");

    doCmd(2, 5);
    doWrite(8, 16'h6666, 16, 0);
    checkWrites("R6 enable then write");
    doCmd(3, 0);
    doWrite(8, 16'h9999, 16, 0);
    checkWrites("R6 disable blocks write");
    doRead(0, 8, 1, 1, "R6 word kept after blocked write");
    doCmd(2, 0);

    doRead(4, 5, 1, 0, "R2 bad start pattern");
    doRead(5, 5, 1, 0, "R2 bad opcode");

    doWrite(6, 16'hFFFF, 4, 0);
    checkWrites("R8 short write frame discarded");
    sendHdr(0, 6);
    for (int b = 0; b < 5; b++) begin waitClk(3); sclk = 1'b1; waitClk(3); sclk = 1'b0; end
    waitClk(2);
    chk(sdoOe == 1'b1, "R8 read driving before abort", int'(sdoOe), 1);
    csN = 1'b1; waitClk(3);
    chk(sdoOe == 1'b0, "R8 read aborted by chip select", int'(sdoOe), 0);
    waitClk(4);
    doRead(0, 6, 1, 1, "R8 word intact after short write");

    finishRun();
  end
endmodule